// File: doc/BRIEF.md
# Four-Level Page Table Walker

This block turns a 48-bit linear address into a physical address by reading one entry from each of four nested tables held in memory. A walk starts from a root frame register, which only a privileged write can change. For each level the walker forms the entry address from the current table base and a 9-bit slice of the linear address. It issues one read over a valid/ready memory port and waits as long as the memory needs. It then checks the returned entry and either descends, finishes with a physical address, or stops with a page fault.

A requester presents an address and a privilege flag with a valid/ready handshake and receives a one-cycle result pulse. The pulse carries the physical address, or a fault flag and the level at which the walk stopped. Only one walk is in flight at a time. Ordinary walks end at a 4 KB frame. A directory entry may instead end the walk at a 2 MB frame.

Top module: `pageWalker`

## Requirements
- R1: After reset `reqReady` is 1, `memReqValid` and `rspValid` are 0, and the root frame is zero.
- R2: The first read of a walk is at `{root frame, addr[47:39], 3'b000}`. Every read address is 8-byte aligned.
- R3: Reads follow a fixed order: top map (index addr[47:39]), pointer table (addr[38:30]), directory (addr[29:21]), page table (addr[20:12]). Each following table base is bits 51:12 of the entry just read.
- R4: A walk that ends at the page-table level returns `{entry[51:12], addr[11:0]}` with `rspFault` = 0.
- R5: An entry with bit 0 (present) clear ends the walk with `rspFault` = 1 and no further reads. `rspFaultLevel` is 3 for the top map, 2 for the pointer table, 1 for the directory and 0 for the page table.
- R6: For a user access (`reqUser` = 1), an entry with bit 2 clear faults at that level. A supervisor access ignores bit 2.
- R7: Bit 7 set in a directory entry ends the walk after three reads with `{entry[51:21], addr[20:0]}`. Bit 7 in a top-map or pointer-table entry has no effect.
- R8: The root frame loads from `rootWrData[51:12]` only when `rootWrEn` and `rootWrPriv` are both 1. A write with `rootWrPriv` = 0 leaves the root unchanged.
- R9: While `memReqValid` is high and `memReqReady` is low, the request and its address stay stable. The walker waits any number of cycles for `memRspValid` before going on.
- R10: `reqReady` is high only when the walker is idle, never while a memory request is pending. `rspValid` is a single-cycle pulse after which the walker is idle again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| rootWrEn | input | 1 | Root register write strobe |
| rootWrPriv | input | 1 | Write comes from privileged mode |
| rootWrData | input | 52 | New root table address (bits 51:12 used) |
| reqValid | input | 1 | Translation request valid |
| reqReady | output | 1 | Walker idle and accepting |
| reqAddr | input | 48 | Linear address to translate |
| reqUser | input | 1 | Access made from user mode |
| memReqValid | output | 1 | Memory read request valid |
| memReqReady | input | 1 | Memory accepts the read |
| memReqAddr | output | 52 | Physical address of the entry to read |
| memRspValid | input | 1 | Read data valid |
| memRspData | input | 64 | Table entry read from memory |
| rspValid | output | 1 | Result pulse |
| rspFault | output | 1 | Walk ended in a page fault |
| rspFaultLevel | output | 2 | Level where the fault occurred |
| rspPhysAddr | output | 52 | Translated physical address |

## Verification
The hardest condition to reach from the ports is a walk that stops at exactly the intended level with the intended cause. Such a walk needs a memory that answers every read with a chosen entry, while the earlier levels still descend correctly. The bench acts as that memory. Each table vector holds the present, user and size flags for every level. The bench builds each returned entry from those flags and a frame number unique to the vector and level. It checks every read address against the chain of frames it has already handed out, and holds off both the read grant and the response for a number of cycles the vector chooses.

// File: rtl/walkerPkg.sv
package walkerPkg;
  typedef enum logic [1:0] {ST_IDLE, ST_ISSUE, ST_WAIT, ST_DONE} walkState_t;

  typedef struct packed {
    logic start;
    logic descend;
    logic finishOk;
    logic finishFault;
  } walkStrobe_t;

  localparam int ENTRY_W     = 64;
  localparam int PRESENT_BIT = 0;
  localparam int USER_BIT    = 2;
  localparam int SIZE_BIT    = 7;
endpackage

// File: rtl/walkCtrl.sv
module walkCtrl
  import walkerPkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  output logic        reqReady,
  output logic        memReqValid,
  input  logic        memReqReady,
  input  logic        memRspValid,
  input  logic        entryFault,
  input  logic        entryLeaf,
  output logic        rspValid,
  output walkStrobe_t strobe
);
  walkState_t stateQ, stateD;

  always_ff @(posedge clk) begin
    if (!rstN) stateQ <= ST_IDLE;
    else       stateQ <= stateD;
  end

  always_comb begin
    stateD      = stateQ;
    strobe      = '0;
    reqReady    = 1'b0;
    memReqValid = 1'b0;
    rspValid    = 1'b0;
    unique case (stateQ)
      ST_IDLE: begin
        reqReady = 1'b1;
        if (reqValid) begin
          strobe.start = 1'b1;
          stateD       = ST_ISSUE;
        end
      end
      ST_ISSUE: begin
        memReqValid = 1'b1;
        if (memReqReady) stateD = ST_WAIT;
      end
      ST_WAIT: begin
        if (memRspValid) begin
          if (entryFault) begin
            strobe.finishFault = 1'b1;
            stateD             = ST_DONE;
          end else if (entryLeaf) begin
            strobe.finishOk = 1'b1;
            stateD          = ST_DONE;
          end else begin
            strobe.descend = 1'b1;
            stateD         = ST_ISSUE;
          end
        end
      end
      ST_DONE: begin
        rspValid = 1'b1;
        stateD   = ST_IDLE;
      end
      default: stateD = ST_IDLE;
    endcase
  end
endmodule

// File: rtl/walkDatapath.sv
module walkDatapath
  import walkerPkg::*;
#(
  parameter int PA_W   = 52,
  parameter int IDX_W  = 9,
  parameter int OFF_W  = 12,
  parameter int LEVELS = 4
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  walkStrobe_t                   strobe,
  input  logic [OFF_W+LEVELS*IDX_W-1:0] reqAddr,
  input  logic                          reqUser,
  input  logic                          rootWrEn,
  input  logic                          rootWrPriv,
  input  logic [PA_W-1:0]               rootWrData,
  input  logic [ENTRY_W-1:0]            memRspData,
  output logic [PA_W-1:0]               memReqAddr,
  output logic                          entryFault,
  output logic                          entryLeaf,
  output logic                          rspFault,
  output logic [$clog2(LEVELS)-1:0]     rspFaultLevel,
  output logic [PA_W-1:0]               rspPhysAddr
);
  localparam int VA_W    = OFF_W + LEVELS * IDX_W;
  localparam int LVL_W   = $clog2(LEVELS);
  localparam int FRAME_W = PA_W - OFF_W;
  localparam int BIG_OFF = OFF_W + IDX_W;

  logic [FRAME_W-1:0] rootQ, baseQ;
  logic [VA_W-1:0]    vaddrQ;
  logic               userQ;
  logic [LVL_W-1:0]   levelQ;
  logic [IDX_W-1:0]   idx;
  logic               bigPage;
  logic               unusedRsp;

  assign idx        = vaddrQ[OFF_W + int'(levelQ) * IDX_W +: IDX_W];
  assign memReqAddr = {baseQ, OFF_W'({idx, 3'b000})};

  assign bigPage    = (levelQ == LVL_W'(1)) && memRspData[SIZE_BIT];
  assign entryFault = !memRspData[PRESENT_BIT] || (userQ && !memRspData[USER_BIT]);
  assign entryLeaf  = (levelQ == '0) || bigPage;

  assign unusedRsp = ^{memRspData[ENTRY_W-1:PA_W], memRspData[OFF_W-1:SIZE_BIT+1],
                       memRspData[SIZE_BIT-1:USER_BIT+1], memRspData[1],
                       rootWrData[OFF_W-1:0]};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rootQ <= '0;
    end else if (rootWrEn && rootWrPriv) begin
      rootQ <= rootWrData[PA_W-1:OFF_W];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      baseQ         <= '0;
      vaddrQ        <= '0;
      userQ         <= 1'b0;
      levelQ        <= '0;
      rspFault      <= 1'b0;
      rspFaultLevel <= '0;
      rspPhysAddr   <= '0;
    end else begin
      if (strobe.start) begin
        vaddrQ <= reqAddr;
        userQ  <= reqUser;
        levelQ <= LVL_W'(LEVELS - 1);
        baseQ  <= rootQ;
      end
      if (strobe.descend) begin
        baseQ  <= memRspData[PA_W-1:OFF_W];
        levelQ <= levelQ - 1'b1;
      end
      if (strobe.finishOk) begin
        rspFault <= 1'b0;
        if (bigPage) rspPhysAddr <= {memRspData[PA_W-1:BIG_OFF], vaddrQ[BIG_OFF-1:0]};
        else         rspPhysAddr <= {memRspData[PA_W-1:OFF_W], vaddrQ[OFF_W-1:0]};
      end
      if (strobe.finishFault) begin
        rspFault      <= 1'b1;
        rspFaultLevel <= levelQ;
        rspPhysAddr   <= '0;
      end
    end
  end
endmodule

// File: rtl/pageWalker.sv
module pageWalker
  import walkerPkg::*;
#(
  parameter int PA_W   = 52,
  parameter int IDX_W  = 9,
  parameter int OFF_W  = 12,
  parameter int LEVELS = 4
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          rootWrEn,
  input  logic                          rootWrPriv,
  input  logic [PA_W-1:0]               rootWrData,
  input  logic                          reqValid,
  output logic                          reqReady,
  input  logic [OFF_W+LEVELS*IDX_W-1:0] reqAddr,
  input  logic                          reqUser,
  output logic                          memReqValid,
  input  logic                          memReqReady,
  output logic [PA_W-1:0]               memReqAddr,
  input  logic                          memRspValid,
  input  logic [ENTRY_W-1:0]            memRspData,
  output logic                          rspValid,
  output logic                          rspFault,
  output logic [$clog2(LEVELS)-1:0]     rspFaultLevel,
  output logic [PA_W-1:0]               rspPhysAddr
);
  walkStrobe_t strobe;
  logic        entryFault, entryLeaf;

  walkCtrl i_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .memReqValid(memReqValid), .memReqReady(memReqReady), .memRspValid(memRspValid),
    .entryFault(entryFault), .entryLeaf(entryLeaf), .rspValid(rspValid), .strobe(strobe)
  );

  walkDatapath #(.PA_W(PA_W), .IDX_W(IDX_W), .OFF_W(OFF_W), .LEVELS(LEVELS)) i_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .reqAddr(reqAddr), .reqUser(reqUser),
    .rootWrEn(rootWrEn), .rootWrPriv(rootWrPriv), .rootWrData(rootWrData),
    .memRspData(memRspData), .memReqAddr(memReqAddr), .entryFault(entryFault),
    .entryLeaf(entryLeaf), .rspFault(rspFault), .rspFaultLevel(rspFaultLevel),
    .rspPhysAddr(rspPhysAddr)
  );
endmodule

// File: rtl/walkerChecker.sv
module walkerChecker #(
  parameter int PA_W  = 52,
  parameter int OFF_W = 12,
  parameter int VA_W  = 48
) (
  input logic            clk,
  input logic            rstN,
  input logic            reqValid,
  input logic            reqReady,
  input logic [VA_W-1:0] reqAddr,
  input logic            memReqValid,
  input logic            memReqReady,
  input logic [PA_W-1:0] memReqAddr,
  input logic            rspValid,
  input logic            rspFault,
  input logic [PA_W-1:0] rspPhysAddr
);
  logic [OFF_W-1:0] lastOff;

  always_ff @(posedge clk) begin
    if (!rstN) lastOff <= '0;
    else if (reqValid && reqReady) lastOff <= reqAddr[OFF_W-1:0];
  end

  AST_ENTRY_ALIGNED: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid |-> memReqAddr[2:0] == 3'b000); // R2

  AST_OFFSET_PASSES: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && !rspFault) |-> rspPhysAddr[OFF_W-1:0] == lastOff); // R4

  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (memReqValid && !memReqReady) |=> (memReqValid && $stable(memReqAddr))); // R9

  AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid |-> !reqReady); // R10

  AST_RESULT_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |=> (!rspValid && reqReady)); // R10
endmodule

bind pageWalker walkerChecker #(.PA_W(PA_W), .OFF_W(OFF_W), .VA_W(OFF_W + LEVELS * IDX_W)) i_checker (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady), .reqAddr(reqAddr),
  .memReqValid(memReqValid), .memReqReady(memReqReady), .memReqAddr(memReqAddr),
  .rspValid(rspValid), .rspFault(rspFault), .rspPhysAddr(rspPhysAddr)
);

// File: tb/test_pageWalker.sv
`timescale 1ns/1ps
module test_pageWalker;
  typedef struct packed {
    logic [47:0] vaddr;
    logic        user;
    logic [11:0] flags;    // per level {size,user,present}, top level in [11:9]
    logic [1:0]  lat;
    logic        expFault;
    logic [1:0]  expLevel;
    logic [2:0]  expReads;
  } vec_t;

  localparam int NVEC = 12;
  localparam vec_t VECS [NVEC] = '{
    '{48'h1234_5678_9ABC, 1'b0, 12'h249, 2'd0, 1'b0, 2'd0, 3'd4},
    '{48'h7FFF_0000_1FFF, 1'b1, 12'h6DB, 2'd2, 1'b0, 2'd0, 3'd4},
    '{48'hABCD_EF01_2345, 1'b0, 12'h049, 2'd1, 1'b1, 2'd3, 3'd1},
    '{48'h0000_4000_0008, 1'b0, 12'h209, 2'd0, 1'b1, 2'd2, 3'd2},
    '{48'hFFFF_FFFF_F000, 1'b0, 12'h241, 2'd3, 1'b1, 2'd1, 3'd3},
    '{48'h0123_4567_89AB, 1'b0, 12'h248, 2'd1, 1'b1, 2'd0, 3'd4},
    '{48'h5555_AAAA_5555, 1'b1, 12'h6CB, 2'd0, 1'b1, 2'd1, 3'd3},
    '{48'h0F0F_0F0F_0F0F, 1'b0, 12'hA49, 2'd1, 1'b0, 2'd0, 3'd4},
    '{48'h3210_0ABC_DEF0, 1'b0, 12'h269, 2'd2, 1'b0, 2'd0, 3'd3},
    '{48'h1111_2222_3333, 1'b0, 12'h349, 2'd1, 1'b0, 2'd0, 3'd4},
    '{48'h2468_ACE0_1357, 1'b1, 12'h6D9, 2'd1, 1'b1, 2'd0, 3'd4},
    '{48'h7654_3210_FEDC, 1'b1, 12'h6FB, 2'd3, 1'b0, 2'd0, 3'd3}
  };

  logic        clk = 1'b0;
  logic        rstN;
  logic        rootWrEn, rootWrPriv;
  logic [51:0] rootWrData;
  logic        reqValid, reqReady, reqUser;
  logic [47:0] reqAddr;
  logic        memReqValid, memReqReady, memRspValid;
  logic [51:0] memReqAddr;
  logic [63:0] memRspData;
  logic        rspValid, rspFault;
  logic [1:0]  rspFaultLevel;
  logic [51:0] rspPhysAddr;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  pageWalker i_pageWalker (
    .clk(clk), .rstN(rstN), .rootWrEn(rootWrEn), .rootWrPriv(rootWrPriv),
    .rootWrData(rootWrData), .reqValid(reqValid), .reqReady(reqReady), .reqAddr(reqAddr),
    .reqUser(reqUser), .memReqValid(memReqValid), .memReqReady(memReqReady),
    .memReqAddr(memReqAddr), .memRspValid(memRspValid), .memRspData(memRspData),
    .rspValid(rspValid), .rspFault(rspFault), .rspFaultLevel(rspFaultLevel),
    .rspPhysAddr(rspPhysAddr)
  );

  task automatic chk(input logic ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [39:0] frameOf(input int vi, input int s);
    return {8'hC5, 8'(vi), 20'h5A5A5, 4'(s)};
  endfunction

  function automatic logic [63:0] mkEntry(input logic [39:0] frame, input logic [2:0] f);
    return {12'h000, frame, 4'h0, f[2], 4'h0, f[1], 1'b1, f[0]};
  endfunction

  task automatic rootWrite(input logic [51:0] val, input logic priv);
    @(negedge clk);
    rootWrEn = 1'b1; rootWrPriv = priv; rootWrData = val;
    @(negedge clk);
    rootWrEn = 1'b0; rootWrPriv = 1'b0;
  endtask

  task automatic runWalk(input int vi, input vec_t v, input logic [39:0] rootExp);
    logic [39:0] base;
    logic [51:0] expAddr;
    logic [51:0] expPa;
    logic [63:0] ent;
    logic [8:0]  idx;
    logic [2:0]  f;
    int          reads;
    int          guard;
    logic        done;
    base = rootExp; reads = 0; guard = 0; done = 1'b0;
    @(negedge clk);
    chk(reqReady, "R10 idle ready before request", 64'(reqReady), 64'd1);
    reqAddr = v.vaddr; reqUser = v.user; reqValid = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
    chk(!reqReady, "R10 busy not ready", 64'(reqReady), 64'd0);
    while (!done && guard < 400) begin
      guard++;
      if (rspValid) begin
        done = 1'b1;
      end else if (memReqValid) begin
        idx     = v.vaddr[47 - 9*reads -: 9];
        expAddr = {base, idx, 3'b000};
        chk(memReqAddr == expAddr, (reads == 0) ? "R2 first entry address" : "R3 next entry address",
            64'(memReqAddr), 64'(expAddr));
        for (int w = 0; w < int'(v.lat); w++) begin
          @(negedge clk);
          chk(memReqValid && memReqAddr == expAddr, "R9 request held", 64'(memReqAddr), 64'(expAddr));
        end
        memReqReady = 1'b1;
        @(negedge clk);
        memReqReady = 1'b0;
        for (int w = 0; w < int'(v.lat); w++) @(negedge clk);
        f   = v.flags[(3 - reads) * 3 +: 3];
        ent = mkEntry(frameOf(vi, reads), f);
        memRspValid = 1'b1; memRspData = ent;
        @(negedge clk);
        memRspValid = 1'b0; memRspData = '0;
        base = frameOf(vi, reads);
        reads++;
      end else begin
        @(negedge clk);
      end
    end
    chk(done, "R9 walk completes", 64'(done), 64'd1);
    chk(reads == int'(v.expReads), "R3 read count", 64'(reads), 64'(v.expReads));
    chk(rspFault == v.expFault, v.user ? "R6 fault flag" : "R5 fault flag", 64'(rspFault), 64'(v.expFault));
    if (v.expFault) begin
      chk(rspFaultLevel == v.expLevel, "R5 fault level", 64'(rspFaultLevel), 64'(v.expLevel));
    end else begin
      if (v.expReads == 3'd3) begin
        expPa = {frameOf(vi, 2)[39:9], v.vaddr[20:0]};
        chk(rspPhysAddr == expPa, "R7 2MB physical address", 64'(rspPhysAddr), 64'(expPa));
      end else begin
        expPa = {frameOf(vi, 3), v.vaddr[11:0]};
        chk(rspPhysAddr == expPa, "R4 4KB physical address", 64'(rspPhysAddr), 64'(expPa));
      end
    end
    @(negedge clk);
    chk(!rspValid && reqReady, "R10 single pulse then idle", 64'({rspValid, reqReady}), 64'b01);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [39:0] rootFrame;
    rstN = 1'b0; rootWrEn = 1'b0; rootWrPriv = 1'b0; rootWrData = '0;
    reqValid = 1'b0; reqAddr = '0; reqUser = 1'b0;
    memReqReady = 1'b0; memRspValid = 1'b0; memRspData = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk(reqReady && !memReqValid && !rspValid, "R1 reset outputs",
        64'({reqReady, memReqValid, rspValid}), 64'b100);

    // R1: root is zero after reset, seen in the first read address
    runWalk(20, '{48'h0000_0000_0000, 1'b0, 12'h049, 2'd0, 1'b1, 2'd3, 3'd1}, 40'h0);

    rootFrame = 40'h98_7654_3210;
    rootWrite({rootFrame, 12'hABC}, 1'b1);
    for (int i = 0; i < NVEC; i++) runWalk(i, VECS[i], rootFrame);

    // R8: user-mode root write is rejected
    rootWrite({40'hFF_EEEE_DDDD, 12'h000}, 1'b0);
    runWalk(21, VECS[0], rootFrame);
    // R8: privileged write takes effect
    rootWrite({40'h01_2345_6789, 12'h000}, 1'b1);
    runWalk(22, VECS[8], 40'h01_2345_6789);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule